// File: doc/BRIEF.md
# Dispatch Slot Allocator with Carry-Over

This block decides, on each clock, whether the instruction waiting at its input may enter the out-of-order back end. It enforces a fixed per-cycle micro-op budget. A dispatch cycle is opened by a `cycle_start` strobe. Between two strobes, several instructions may be offered one per clock, and each one that is accepted draws slots from the budget of the current dispatch cycle. The budget is refilled only at the next strobe.

An instruction carrying more micro-ops than the budget fills the whole cycle in which it is accepted. The surplus is held in a carry-over count. At each following `cycle_start`, as much of that surplus as fits is drained and reported, and no new instruction is accepted until the surplus is gone. Begin-group and end-group flags force an instruction to open a fresh dispatch cycle or to close the current one. Readiness of the retire buffer, of the rename stage's free registers and of the downstream stage enter as three single-bit inputs. A refusal raises a stall flag that names its cause.

Top module: `dispatch_slot_alloc`

## Requirements
- R1: After reset the carry-over is clear and the full budget W is available without waiting for a `cycle_start`, so an instruction of W micro-ops marked begin-group is accepted on the first clock; `carry_valid` is low.
- R2: An instruction is refused (`in_ready` low, `stall_slots` high) when its slot need min(count, W) exceeds the remaining slots or no slot remains. Remaining slots persist across clocks without `cycle_start` and are refilled to W on a `cycle_start` when no carry-over is pending.
- R3: Each accepted instruction of count at most W reports `disp_uops` equal to its count and lowers the remaining slots of the dispatch cycle by that count.
- R4: An accepted instruction whose count exceeds W reports `disp_uops` = W, leaves no slot for the rest of that dispatch cycle and records count minus W as carry-over.
- R5: On each `cycle_start` clock with carry-over C pending, `carry_valid` is high and `carry_uops` = min(C, W), and C drops by that amount. While carry-over remains after that, `in_ready` stays low. `carry_valid` is low on every other clock.
- R6: On the `cycle_start` where the carry-over C (C < W) is drained, W minus C slots remain for new instructions in that same dispatch cycle. When C equals W, no slot remains.
- R7: An instruction marked begin-group is accepted only while the remaining slot count equals W.
- R8: After an instruction marked end-group is accepted, no further instruction is accepted until the next `cycle_start`.
- R9: Acceptance requires `rob_room`, `regs_room` and `down_ready` all high. A refused attempt consumes no slots.
- R10: When the slot check passes but a readiness input is low, `stall_rob`, `stall_regs` and `stall_down` each reflect their own input, independently of each other, and `stall_slots` is low. All stall flags are low when `in_valid` is low or the instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_start | input | 1 | Opens a new dispatch cycle on this clock |
| in_valid | input | 1 | An instruction is offered |
| in_uops | input | UOP_W | Micro-op count of the offered instruction (1..MAX_UOPS) |
| in_begin | input | 1 | Instruction must open a dispatch cycle |
| in_end | input | 1 | Instruction closes its dispatch cycle |
| in_ready | output | 1 | Offered instruction would be accepted this clock |
| rob_room | input | 1 | Retire buffer has room for the full micro-op count |
| regs_room | input | 1 | Rename stage has the destination registers |
| down_ready | input | 1 | Downstream stage accepts an instruction |
| disp_valid | output | 1 | An instruction is accepted this clock |
| disp_uops | output | SLOT_W | Micro-ops dispatched for the accepted instruction |
| carry_valid | output | 1 | Carried micro-ops are dispatched this clock |
| carry_uops | output | SLOT_W | Number of carried micro-ops dispatched |
| stall_slots | output | 1 | Refused for lack of slots or pending carry-over |
| stall_rob | output | 1 | Refused because the retire buffer is full |
| stall_regs | output | 1 | Refused because no free destination register |
| stall_down | output | 1 | Refused because the downstream stage is busy |

## Verification
Mixtures of small instructions packed into one dispatch cycle show whether the budget is drawn down by the right amounts and whether it persists until the next cycle start. Oversized instructions of 10, 8 and 16 micro-ops separate three carry paths: a partial tail that leaves slots free, a tail that equals the width and leaves none, and several full carry beats in a row. Begin-group and end-group instructions placed mid-cycle and at a cycle start distinguish the group rules from plain budget refusals. Readiness inputs dropped singly and in pairs show that each stall reason is reported on its own and that a refused attempt draws no slots.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

  // Slots an instruction occupies in the cycle it is accepted.
  function automatic int need_slots(input int uops, input int width);
    return (uops < width) ? uops : width;
  endfunction

  // Slots left for new work when a dispatch cycle opens with a given carry.
  function automatic int start_avail(input int carry, input int width);
    if (carry == 0) return width;
    if (carry >= width) return 0;
    return width - carry;
  endfunction

  // Micro-ops left over after an instruction takes one full cycle.
  function automatic int excess_uops(input int uops, input int width);
    return (uops > width) ? uops - width : 0;
  endfunction

endpackage

// File: rtl/dsa_window.sv
module dsa_window #(
  parameter int W      = 4,
  parameter int UOP_W  = 5,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycle_start,
  input  logic              fire,
  input  logic [UOP_W-1:0]  fire_uops,
  input  logic [SLOT_W-1:0] fire_need,
  input  logic              fire_end,
  output logic [SLOT_W-1:0] avail_now,
  output logic              carry_beat,
  output logic [SLOT_W-1:0] carry_take,
  output logic              carry_left_nz
);

  localparam logic [SLOT_W-1:0] FULL_S = SLOT_W'(W);
  localparam logic [UOP_W-1:0]  FULL_U = UOP_W'(W);

  logic [SLOT_W-1:0] avail_q;
  logic [UOP_W-1:0]  carry_q;
  logic [UOP_W-1:0]  carry_left;
  logic [SLOT_W-1:0] avail_after;
  logic [UOP_W-1:0]  fire_excess;
  logic              fire_wide;

  // Budget and carry seen by this clock, after any cycle-start refill.
  always_comb begin
    carry_beat = cycle_start && (carry_q != '0);
    if (cycle_start)
      avail_now = SLOT_W'(dsa_pkg::start_avail(int'(carry_q), W));
    else
      avail_now = avail_q;
    carry_take    = carry_beat ? (FULL_S - avail_now) : '0;
    carry_left    = carry_beat ? (carry_q - UOP_W'(carry_take)) : carry_q;
    carry_left_nz = (carry_left != '0);
  end

  // Effect of the accepted instruction on the running budget.
  always_comb begin
    fire_wide   = (fire_uops > FULL_U);
    fire_excess = UOP_W'(dsa_pkg::excess_uops(int'(fire_uops), W));
    if (fire_wide || fire_end)
      avail_after = '0;
    else
      avail_after = avail_now - fire_need;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= FULL_S;
      carry_q <= '0;
    end else if (fire) begin
      avail_q <= avail_after;
      carry_q <= fire_excess;
    end else begin
      avail_q <= avail_now;
      carry_q <= carry_left;
    end
  end

endmodule

// File: rtl/dsa_admit.sv
module dsa_admit #(
  parameter int W      = 4,
  parameter int UOP_W  = 5,
  parameter int SLOT_W = 3
) (
  input  logic              in_valid,
  input  logic [UOP_W-1:0]  in_uops,
  input  logic              in_begin,
  input  logic [SLOT_W-1:0] avail_now,
  input  logic              carry_left_nz,
  input  logic              rob_room,
  input  logic              regs_room,
  input  logic              down_ready,
  output logic [SLOT_W-1:0] need,
  output logic              in_ready,
  output logic              fire,
  output logic              stall_slots,
  output logic              stall_rob,
  output logic              stall_regs,
  output logic              stall_down
);

  localparam logic [SLOT_W-1:0] FULL_S = SLOT_W'(W);

  logic slot_ok;
  logic res_ok;

  always_comb begin
    need    = SLOT_W'(dsa_pkg::need_slots(int'(in_uops), W));
    slot_ok = !carry_left_nz
              && (avail_now != '0)
              && (need <= avail_now)
              && (!in_begin || (avail_now == FULL_S));
    res_ok  = rob_room && regs_room && down_ready;
    in_ready = slot_ok && res_ok;
    fire     = in_valid && in_ready;
    stall_slots = in_valid && !slot_ok;
    stall_rob   = in_valid && slot_ok && !rob_room;
    stall_regs  = in_valid && slot_ok && !regs_room;
    stall_down  = in_valid && slot_ok && !down_ready;
  end

endmodule

// File: rtl/dispatch_slot_alloc.sv
module dispatch_slot_alloc #(
  parameter int W        = 4,
  parameter int MAX_UOPS = 16,
  localparam int UOP_W   = $clog2(MAX_UOPS + 1),
  localparam int SLOT_W  = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cycle_start,
  input  logic              in_valid,
  input  logic [UOP_W-1:0]  in_uops,
  input  logic              in_begin,
  input  logic              in_end,
  output logic              in_ready,
  input  logic              rob_room,
  input  logic              regs_room,
  input  logic              down_ready,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] disp_uops,
  output logic              carry_valid,
  output logic [SLOT_W-1:0] carry_uops,
  output logic              stall_slots,
  output logic              stall_rob,
  output logic              stall_regs,
  output logic              stall_down
);

  // Named internal events, also watched by the bound checker.
  logic [SLOT_W-1:0] avail_now;
  logic [SLOT_W-1:0] need_now;
  logic              carry_beat;
  logic [SLOT_W-1:0] carry_take;
  logic              carry_left_nz;
  logic              fire;

  dsa_window #(.W(W), .UOP_W(UOP_W), .SLOT_W(SLOT_W)) u_window (
    .clk           (clk),
    .rst           (rst),
    .cycle_start   (cycle_start),
    .fire          (fire),
    .fire_uops     (in_uops),
    .fire_need     (need_now),
    .fire_end      (in_end),
    .avail_now     (avail_now),
    .carry_beat    (carry_beat),
    .carry_take    (carry_take),
    .carry_left_nz (carry_left_nz)
  );

  dsa_admit #(.W(W), .UOP_W(UOP_W), .SLOT_W(SLOT_W)) u_admit (
    .in_valid      (in_valid),
    .in_uops       (in_uops),
    .in_begin      (in_begin),
    .avail_now     (avail_now),
    .carry_left_nz (carry_left_nz),
    .rob_room      (rob_room),
    .regs_room     (regs_room),
    .down_ready    (down_ready),
    .need          (need_now),
    .in_ready      (in_ready),
    .fire          (fire),
    .stall_slots   (stall_slots),
    .stall_rob     (stall_rob),
    .stall_regs    (stall_regs),
    .stall_down    (stall_down)
  );

  assign disp_valid  = fire;
  assign disp_uops   = fire ? need_now : '0;
  assign carry_valid = carry_beat;
  assign carry_uops  = carry_take;

endmodule

// File: rtl/dsa_checker.sv
module dsa_checker #(
  parameter int W      = 4,
  parameter int UOP_W  = 5,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cycle_start,
  input logic [UOP_W-1:0]  in_uops,
  input logic              in_begin,
  input logic              in_end,
  input logic              in_ready,
  input logic              rob_room,
  input logic              regs_room,
  input logic              down_ready,
  input logic              disp_valid,
  input logic [SLOT_W-1:0] disp_uops,
  input logic              carry_valid,
  input logic [SLOT_W-1:0] carry_uops,
  input logic [SLOT_W-1:0] avail_now,
  input logic [SLOT_W-1:0] need_now,
  input logic              stall_any
);

  localparam logic [SLOT_W-1:0] FULL_S = SLOT_W'(W);
  localparam logic [UOP_W-1:0]  FULL_U = UOP_W'(W);

  // R2
  fits_budget_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> (avail_now != '0) && (need_now <= avail_now));

  // R3
  budget_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && (in_uops <= FULL_U) && !in_end) |=>
      (cycle_start || (avail_now == ($past(avail_now) - $past(need_now)))));

  // R4
  wide_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && (in_uops > FULL_U)) |-> (disp_uops == FULL_S));

  // R5
  carry_beat_chk: assert property (@(posedge clk) disable iff (rst)
    carry_valid |-> (cycle_start && (carry_uops != '0) && (carry_uops <= FULL_S)));

  // R7
  begin_full_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && in_begin) |-> (avail_now == FULL_S));

  // R8
  end_close_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && in_end) |=> (cycle_start || !in_ready));

  // R9
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (rob_room && regs_room && down_ready));

  // R10
  no_stall_on_fire_chk: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> !stall_any);

endmodule

bind dispatch_slot_alloc dsa_checker #(.W(W), .UOP_W(UOP_W), .SLOT_W(SLOT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cycle_start (cycle_start),
  .in_uops     (in_uops),
  .in_begin    (in_begin),
  .in_end      (in_end),
  .in_ready    (in_ready),
  .rob_room    (rob_room),
  .regs_room   (regs_room),
  .down_ready  (down_ready),
  .disp_valid  (disp_valid),
  .disp_uops   (disp_uops),
  .carry_valid (carry_valid),
  .carry_uops  (carry_uops),
  .avail_now   (avail_now),
  .need_now    (need_now),
  .stall_any   (stall_slots || stall_rob || stall_regs || stall_down)
);

// File: tb/dispatch_slot_alloc_test.sv
`timescale 1ns/1ps
module dispatch_slot_alloc_test;

  localparam int W = 4;
  localparam int MAXU = 16;
  localparam int UW = $clog2(MAXU + 1);
  localparam int SW = $clog2(W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cycle_start = 1'b0, in_valid = 1'b0, in_begin = 1'b0, in_end = 1'b0;
  logic [UW-1:0] in_uops = '0;
  logic rob_room = 1'b1, regs_room = 1'b1, down_ready = 1'b1;
  logic in_ready, disp_valid, carry_valid;
  logic [SW-1:0] disp_uops, carry_uops;
  logic stall_slots, stall_rob, stall_regs, stall_down;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dispatch_slot_alloc #(.W(W), .MAX_UOPS(MAXU)) uut (
    .clk(clk), .rst(rst), .cycle_start(cycle_start),
    .in_valid(in_valid), .in_uops(in_uops), .in_begin(in_begin), .in_end(in_end),
    .in_ready(in_ready), .rob_room(rob_room), .regs_room(regs_room),
    .down_ready(down_ready), .disp_valid(disp_valid), .disp_uops(disp_uops),
    .carry_valid(carry_valid), .carry_uops(carry_uops),
    .stall_slots(stall_slots), .stall_rob(stall_rob),
    .stall_regs(stall_regs), .stall_down(stall_down)
  );

  function automatic int min_w(input int n);
    return (n < W) ? n : W;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Apply inputs for one clock; outputs settle before the next edge.
  task automatic drive(input bit cs, input bit v, input int u, input bit b, input bit e,
                       input bit rb, input bit rg, input bit dn);
    @(negedge clk);
    cycle_start = cs; in_valid = v; in_uops = UW'(u); in_begin = b; in_end = e;
    rob_room = rb; regs_room = rg; down_ready = dn;
    #1;
  endtask

  task automatic expect_fire(input string tag, input int u);
    check(tag, "in_ready", int'(in_ready), 1);
    check(tag, "disp_uops", int'(disp_uops), min_w(u));
  endtask

  task automatic expect_refuse(input string tag);
    check(tag, "in_ready", int'(in_ready), 0);
    check(tag, "stall_slots", int'(stall_slots), 1);
    check(tag, "disp_valid", int'(disp_valid), 0);
  endtask

  task automatic t_reset();
    drive(0, 1, W, 1, 0, 1, 1, 1);
    check("R1", "carry_valid", int'(carry_valid), 0);
    expect_fire("R1", W);
    drive(0, 1, 1, 0, 0, 1, 1, 1);
    expect_refuse("R2");
  endtask

  task automatic t_pack();
    drive(1, 1, 1, 0, 0, 1, 1, 1);
    expect_fire("R3", 1);
    drive(0, 1, 3, 0, 0, 1, 1, 1);
    expect_fire("R3", 3);
    drive(0, 1, 1, 0, 0, 1, 1, 1);
    expect_refuse("R3");
    drive(1, 1, 2, 0, 0, 1, 1, 1);
    expect_fire("R2", 2);
    drive(0, 1, 3, 0, 0, 1, 1, 1);
    expect_refuse("R2");
  endtask

  task automatic t_partial_tail();
    drive(1, 1, 10, 0, 0, 1, 1, 1);
    expect_fire("R4", 10);
    drive(0, 1, 1, 0, 0, 1, 1, 1);
    expect_refuse("R4");
    drive(1, 1, 1, 0, 0, 1, 1, 1);
    check("R5", "carry_valid", int'(carry_valid), 1);
    check("R5", "carry_uops", int'(carry_uops), min_w(10 - W));
    expect_refuse("R5");
    drive(1, 1, 3, 0, 0, 1, 1, 1);
    check("R6", "carry_uops", int'(carry_uops), 10 - 2 * W);
    expect_refuse("R6");
    drive(0, 1, 2, 0, 0, 1, 1, 1);
    check("R5", "carry_valid off", int'(carry_valid), 0);
    expect_fire("R6", 2);
    drive(0, 1, 1, 0, 0, 1, 1, 1);
    expect_refuse("R6");
  endtask

  task automatic t_exact_tail();
    drive(1, 1, 2 * W, 0, 0, 1, 1, 1);
    expect_fire("R4", 2 * W);
    drive(1, 1, 1, 0, 0, 1, 1, 1);
    check("R6", "carry_uops", int'(carry_uops), W);
    expect_refuse("R6");
    drive(1, 1, 1, 0, 0, 1, 1, 1);
    check("R5", "carry_valid", int'(carry_valid), 0);
    expect_fire("R6", 1);
  endtask

  task automatic t_max_tail();
    int left = MAXU - W;
    drive(1, 1, MAXU, 0, 0, 1, 1, 1);
    expect_fire("R4", MAXU);
    while (left > 0) begin
      drive(1, 1, 1, 0, 0, 1, 1, 1);
      check("R5", "carry_valid", int'(carry_valid), 1);
      check("R5", "carry_uops", int'(carry_uops), min_w(left));
      left = left - min_w(left);
      expect_refuse("R5");
    end
    drive(1, 1, 1, 0, 0, 1, 1, 1);
    expect_fire("R5", 1);
  endtask

  task automatic t_groups();
    drive(1, 1, 1, 0, 0, 1, 1, 1);
    expect_fire("R7", 1);
    drive(0, 1, 1, 1, 0, 1, 1, 1);
    expect_refuse("R7");
    drive(1, 1, 1, 1, 0, 1, 1, 1);
    expect_fire("R7", 1);
    drive(1, 1, 1, 0, 1, 1, 1, 1);
    expect_fire("R8", 1);
    drive(0, 1, 1, 0, 0, 1, 1, 1);
    expect_refuse("R8");
    drive(1, 1, 1, 0, 0, 1, 1, 1);
    expect_fire("R8", 1);
  endtask

  task automatic t_readiness();
    drive(1, 1, 1, 0, 0, 0, 1, 1);
    check("R9", "in_ready", int'(in_ready), 0);
    check("R10", "stall_rob", int'(stall_rob), 1);
    check("R10", "stall_regs", int'(stall_regs), 0);
    check("R10", "stall_down", int'(stall_down), 0);
    check("R10", "stall_slots", int'(stall_slots), 0);
    drive(0, 1, 1, 0, 0, 1, 0, 1);
    check("R10", "stall_regs only", int'({stall_rob, stall_regs, stall_down}), 3'b010);
    drive(0, 1, 1, 0, 0, 1, 1, 0);
    check("R10", "stall_down only", int'({stall_rob, stall_regs, stall_down}), 3'b001);
    drive(0, 1, 1, 0, 0, 0, 0, 1);
    check("R10", "rob and regs", int'({stall_rob, stall_regs, stall_down}), 3'b110);
    drive(0, 1, W, 0, 0, 1, 1, 1);
    expect_fire("R9", W);
    check("R10", "no stall on fire", int'({stall_slots, stall_rob, stall_regs, stall_down}), 0);
    drive(0, 0, 1, 0, 0, 0, 0, 0);
    check("R10", "idle stalls", int'({stall_slots, stall_rob, stall_regs, stall_down}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pack();
    t_partial_tail();
    t_exact_tail();
    t_max_tail();
    t_groups();
    t_readiness();
    drive(0, 0, 0, 0, 0, 1, 1, 1);
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule